// File: doc/BRIEF.md
# Cascadable Decade Counter Stage

This block is one decimal digit of a synchronous counter. It holds a value from 0 to 9 and advances it by one on a rising clock edge when both of its count enables are high, wrapping from 9 to 0. It can also be cleared to zero or loaded with a preset value. Both operations are synchronous and take effect on the clock edge. Clear has the highest priority, then load, then counting.

Several stages chain into a multi-digit counter. All stages share the same clock and the same step enable. Each stage's carry output drives the chain enable of the next, more significant stage. The carry is combinational and depends only on the chain enable and the stored digit, so a carry ripples through a chain without waiting for any clock.

If the stage holds a code from 10 to 15, for example after a load of such a value, a single counting edge returns it to 0.

Top module: `decade_stage`

## Requirements
- R1: When `rst_n` is 0 at a rising edge, `q` becomes 0 after that edge, whatever `load_n`, `din`, `step_en` and `chain_en` are.
- R2: When `rst_n` is 1 and `load_n` is 0 at a rising edge, `q` takes the value of `din` after that edge, whatever the two enables are. A code from 10 to 15 is loaded unchanged.
- R3: When `rst_n`, `load_n`, `step_en` and `chain_en` are all 1 at a rising edge, `q` advances by one from 0 to 8, and goes from 9 to 0.
- R4: When `rst_n` and `load_n` are 1 and either `step_en` or `chain_en` is 0 at a rising edge, `q` keeps its value.
- R5: `carry_out` is 1 exactly when `chain_en` is 1 and `q` is 9. It follows these inputs without waiting for a clock edge, and `step_en` has no effect on it.
- R6: A counting edge taken while `q` holds any code from 10 to 15 sets `q` to 0.
- R7: In a two-digit chain, the low stage's `carry_out` drives the high stage's `chain_en`. With counting enabled, the pair steps through 00 to 99 and then returns to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst_n | input | 1 | Synchronous clear, active low |
| load_n | input | 1 | Synchronous preset from `din`, active low |
| din | input | 4 | Preset value |
| step_en | input | 1 | Count enable that is shared by all stages of a chain |
| chain_en | input | 1 | Count enable that also gates `carry_out`; takes the previous stage's carry |
| q | output | 4 | Stored digit |
| carry_out | output | 1 | Terminal count: digit is 9 and `chain_en` is high |

## Verification
The assertions assume that all inputs change only away from the rising clock edge and are settled at it. The bench drives every input on the falling edge, so this assumption holds.

The load and counting properties are disabled while `rst_n` is low. They therefore assume that a clear cycle separates any use of the digit from its undefined power-up value. The bench holds `rst_n` low for two edges before it drives anything else.

Unused codes reach the stage only through a load. The bench steps through each one, so the recovery rule is tested for every code from 10 to 15 and not only for one of them.

// File: rtl/decade_pkg.sv
// Package: decade_pkg
// Holds the types that the decade counter stage and its submodules share.
// Assumes nothing: it contains only declarations.
package decade_pkg;

    // Operation chosen for the coming clock edge, listed from highest to lowest priority.
    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STEP  = 2'd2,
        OP_HOLD  = 2'd3
    } stage_op_e;

endpackage

// File: rtl/decade_ctrl.sv
// Module: decade_ctrl
// Decodes the control inputs into one operation for the next clock edge.
// Priority is clear, then load, then step; when none of them applies, the digit holds.
// Assumes all inputs are settled before the rising clock edge.
module decade_ctrl
    import decade_pkg::*;
(
    input  logic      rst_n,
    input  logic      load_n,
    input  logic      step_en,
    input  logic      chain_en,
    output stage_op_e op
);

    // Purpose: choose the operation by fixed priority.
    always_comb begin
        if (!rst_n) begin
            op = OP_CLEAR;
        end else if (!load_n) begin
            op = OP_LOAD;
        end else if (step_en && chain_en) begin
            op = OP_STEP;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/decade_next.sv
// Module: decade_next
// Computes the next stored value from the chosen operation.
// A step from the last valid code, or from any code above it, returns to zero.
// Assumes MODULUS is at least 2.
module decade_next
    import decade_pkg::*;
#(
    parameter int MODULUS = 10,
    localparam int W = $clog2(MODULUS)
) (
    input  stage_op_e      op,
    input  logic [W-1:0]   cur,
    input  logic [W-1:0]   preset,
    output logic [W-1:0]   nxt
);

    localparam logic [W-1:0] LAST = W'(MODULUS - 1);

    logic [W-1:0] stepped;

    // Purpose: successor for counting, with wrap and recovery from unused codes.
    always_comb begin
        if (cur >= LAST) begin
            stepped = '0;
        end else begin
            stepped = cur + 1'b1;
        end
    end

    // Purpose: select the next value for the chosen operation.
    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = preset;
            OP_STEP:  nxt = stepped;
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/decade_tc.sv
// Module: decade_tc
// Combinational terminal-count output for look-ahead carry into the next stage.
// Only the chain enable gates it, so a carry passes along a chain with no clock delay.
// Assumes the stored value is stable between clock edges.
module decade_tc #(
    parameter int MODULUS = 10,
    localparam int W = $clog2(MODULUS)
) (
    input  logic [W-1:0] cur,
    input  logic         chain_en,
    output logic         carry
);

    localparam logic [W-1:0] LAST = W'(MODULUS - 1);

    // Purpose: flag the last code while the chain enable is high.
    always_comb begin
        carry = chain_en && (cur == LAST);
    end

endmodule

// File: rtl/decade_stage.sv
// Module: decade_stage
// One cascadable synchronous decade counter stage: clear, load, count and carry.
// All state changes happen on the rising clock edge; rst_n acts as a synchronous clear.
// Assumes the inputs meet setup and hold timing at the clock edge.
module decade_stage #(
    parameter int MODULUS = 10,
    localparam int W = $clog2(MODULUS)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_n,
    input  logic [W-1:0] din,
    input  logic         step_en,
    input  logic         chain_en,
    output logic [W-1:0] q,
    output logic         carry_out
);

    import decade_pkg::*;

    stage_op_e    op;
    logic [W-1:0] digit_q;
    logic [W-1:0] digit_d;

    decade_ctrl u_ctrl (
        .rst_n    (rst_n),
        .load_n   (load_n),
        .step_en  (step_en),
        .chain_en (chain_en),
        .op       (op)
    );

    decade_next #(.MODULUS(MODULUS)) u_next (
        .op     (op),
        .cur    (digit_q),
        .preset (din),
        .nxt    (digit_d)
    );

    decade_tc #(.MODULUS(MODULUS)) u_tc (
        .cur      (digit_q),
        .chain_en (chain_en),
        .carry    (carry_out)
    );

    // Purpose: store the digit; the clear is decoded into digit_d, so it stays synchronous.
    always_ff @(posedge clk) begin
        digit_q <= digit_d;
    end

    assign q = digit_q;

endmodule

// File: rtl/decade_stage_chk.sv
// Module: decade_stage_chk
// Property checker for decade_stage, attached to it by the bind statement at the end of this file.
// Assumes the inputs are settled at each rising clock edge.
module decade_stage_chk #(
    parameter int MODULUS = 10,
    localparam int W = $clog2(MODULUS)
) (
    input logic         clk,
    input logic         rst_n,
    input logic         load_n,
    input logic [W-1:0] din,
    input logic         step_en,
    input logic         chain_en,
    input logic [W-1:0] q,
    input logic         carry_out
);

    localparam logic [W-1:0] LAST = W'(MODULUS - 1);

    // R1: a clear edge leaves the digit at zero.
    a_r1_clear_zero: assert property (@(posedge clk)
        !rst_n |=> (q == '0));

    // R2: a load edge copies din, whatever the enables are.
    a_r2_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> (q == $past(din)));

    // R3 and R6: a counting edge gives the successor; the last code and unused codes go to zero.
    a_r3_step_successor: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && step_en && chain_en) |=>
            (q == (($past(q) >= LAST) ? '0 : ($past(q) + 1'b1))));

    // R4: with either enable low and no load, the digit holds.
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !(step_en && chain_en)) |=> $stable(q));

    // R5: carry needs the chain enable.
    a_r5_carry_needs_chain: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_en |-> !carry_out);

    // R5: carry appears only at the last code.
    a_r5_carry_at_last: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out |-> (q == LAST));

    // R6: after any counting edge, the digit is inside the valid range.
    a_r6_back_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && step_en && chain_en) |=> (q < W'(MODULUS)));

endmodule

bind decade_stage decade_stage_chk #(.MODULUS(MODULUS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_n    (load_n),
    .din       (din),
    .step_en   (step_en),
    .chain_en  (chain_en),
    .q         (q),
    .carry_out (carry_out)
);

// File: tb/decade_stage_test.sv
`timescale 1ns/1ps
// Bench: two chained stages checked against a behavioural model on every cycle.
module decade_stage_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_lo = 1'b1, ld_hi = 1'b1;
    logic [3:0] d_lo = 4'd0, d_hi = 4'd0;
    logic       step = 1'b0, chain = 1'b0;
    logic [3:0] q_lo, q_hi;
    logic       c_lo, c_hi;

    int vectors = 0;
    int misses  = 0;
    int lo_m = 0, hi_m = 0;

    always #5 clk = ~clk;

    decade_stage uut (
        .clk(clk), .rst_n(rst_n), .load_n(ld_lo), .din(d_lo),
        .step_en(step), .chain_en(chain), .q(q_lo), .carry_out(c_lo));

    decade_stage uut_hi (
        .clk(clk), .rst_n(rst_n), .load_n(ld_hi), .din(d_hi),
        .step_en(step), .chain_en(c_lo), .q(q_hi), .carry_out(c_hi));

    // Behavioural next value: clear, then load, then count with wrap, else hold.
    function automatic int model_next(int v, logic r, logic l, logic [3:0] d, logic se, logic ce);
        if (!r) return 0;
        if (!l) return int'(d);
        if (se && ce) return (v >= 9) ? 0 : v + 1;
        return v;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, check the carries, then check the digits after the rising edge.
    task automatic cycle(string tag, logic r, logic l0, logic [3:0] dv0, logic l1,
                         logic [3:0] dv1, logic se, logic ce);
        int e_c0, e_c1, n_lo, n_hi;
        rst_n = r; ld_lo = l0; d_lo = dv0; ld_hi = l1; d_hi = dv1; step = se; chain = ce;
        #1;
        e_c0 = (ce && lo_m == 9) ? 1 : 0;
        e_c1 = (e_c0 == 1 && hi_m == 9) ? 1 : 0;
        check(tag, "low carry", int'(c_lo), e_c0);
        check(tag, "high carry", int'(c_hi), e_c1);
        n_lo = model_next(lo_m, r, l0, dv0, se, ce);
        n_hi = model_next(hi_m, r, l1, dv1, se, e_c0 == 1);
        @(posedge clk);
        @(negedge clk);
        lo_m = n_lo;
        hi_m = n_hi;
        check(tag, "low digit", int'(q_lo), lo_m);
        check(tag, "high digit", int'(q_hi), hi_m);
    endtask

    initial begin
        #2_000_000;
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        // Clear from power-up; the digits are unknown until the first clear edge.
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        lo_m = 0; hi_m = 0;
        cycle("R1", 1'b0, 1'b1, 4'd0, 1'b1, 4'd0, 1'b1, 1'b1);
        // R7: full two-digit sweep past 99 and back through 00.
        for (int i = 0; i < 105; i++)
            cycle("R7", 1'b1, 1'b1, 4'd0, 1'b1, 4'd0, 1'b1, 1'b1);
        // R2: load with both enables low, then hold with each enable low (R4).
        cycle("R2", 1'b1, 1'b0, 4'd9, 1'b0, 4'd3, 1'b0, 1'b0);
        cycle("R4", 1'b1, 1'b1, 4'd0, 1'b1, 4'd0, 1'b0, 1'b1);
        cycle("R4", 1'b1, 1'b1, 4'd0, 1'b1, 4'd0, 1'b1, 1'b0);
        // R5: step_en low leaves the carry high at 9; chain_en low drops it.
        cycle("R5", 1'b1, 1'b1, 4'd0, 1'b1, 4'd0, 1'b0, 1'b1);
        cycle("R5", 1'b1, 1'b1, 4'd0, 1'b1, 4'd0, 1'b0, 1'b0);
        // R3: 9 wraps to 0 and carries into the high digit (3 becomes 4).
        cycle("R3", 1'b1, 1'b1, 4'd0, 1'b1, 4'd0, 1'b1, 1'b1);
        // R2: load while counting is enabled; the load takes priority over counting.
        cycle("R2", 1'b1, 1'b0, 4'd5, 1'b0, 4'd8, 1'b1, 1'b1);
        // R6: each unused code, loaded and then stepped, returns to zero.
        for (int code = 10; code < 16; code++) begin
            cycle("R2", 1'b1, 1'b0, 4'(code), 1'b1, 4'd0, 1'b0, 1'b0);
            cycle("R6", 1'b1, 1'b1, 4'd0, 1'b1, 4'd0, 1'b1, 1'b1);
        end
        // R6: an unused code held while the enables are low stays put (R4).
        cycle("R2", 1'b1, 1'b0, 4'd14, 1'b0, 4'd11, 1'b0, 1'b0);
        cycle("R4", 1'b1, 1'b1, 4'd0, 1'b1, 4'd0, 1'b0, 1'b1);
        cycle("R6", 1'b1, 1'b1, 4'd0, 1'b1, 4'd0, 1'b1, 1'b1);
        // R1: clear overrides a load and the enables.
        cycle("R2", 1'b1, 1'b0, 4'd7, 1'b0, 4'd6, 1'b0, 1'b0);
        cycle("R1", 1'b0, 1'b0, 4'd5, 1'b0, 4'd5, 1'b1, 1'b1);
        // R7: second sweep from zero through the carry.
        for (int i = 0; i < 25; i++)
            cycle("R7", 1'b1, 1'b1, 4'd0, 1'b1, 4'd0, 1'b1, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule